// File: doc/BRIEF.md
# Presettable Cascadable Down Counter

This block is one stage of a programmable frequency divider. It holds a count of `W` bits (four by default) that steps down by one on each count event. There are two sources of count events. The first is a rising edge on the count clock while the inhibit pin is low. The second is a falling edge on the inhibit pin while the count clock is high, so the inhibit pin can act as a negative-edge clock. A parameter picks either decade counting, which wraps from 0 to 9, or full binary counting, which wraps from 0 to the all-ones value.

Both pins are sampled in the system clock domain. A count edge is found by comparing each pin with a registered copy, so at most one decrement happens per system cycle. A clear input forces the count to zero, and a load input copies the preset value into the count. Both act at the next system clock edge, and clear wins over load, which wins over counting.

The zero flag is high when the count is zero and the cascade input is high. It is gated by the clear and load state, so a stage can drive the load input of its own stage, or the cascade input of the next stage, with no glue logic. In a single stage the flag is wired to the load input, and the stage then pulses once every N count edges. The inputs are assumed to be synchronous to the system clock.

Top module: `divn_down_counter`

## Requirements
- R1: With `inhibit_i` low, a 0-to-1 change of `cnt_clk_i` between two system edges lowers `count_o` by one, visible after the second edge.
- R2: With `cnt_clk_i` high, a 1-to-0 change of `inhibit_i` lowers `count_o` by one in the same way.
- R3: These leave `count_o` unchanged: a rising count clock while inhibit is high, any inhibit change while the count clock is low, a falling count clock, and a rising inhibit.
- R4: `clear_i` high at a system edge sets `count_o` to 0. It overrides `load_i` and any count event.
- R5: `load_i` high with `clear_i` low at a system edge sets `count_o` to `preset_i`. It overrides any count event.
- R6: After an edge that sampled both `clear_i` and `load_i` low, `zero_o` equals (`count_o` == 0) AND `cascade_i`.
- R7: After an edge that sampled `clear_i` high, `zero_o` equals the sampled `load_i` OR `cascade_i`.
- R8: After an edge that sampled `load_i` high and `clear_i` low, `zero_o` is 0.
- R9: A decrement from 0 gives 9 in decade mode (`MODE` = CNT_BCD) and 15 in binary mode (`MODE` = CNT_BIN). In decade mode, values from 10 to 15 step down by one as usual.
- R10: When a rising count clock and a falling inhibit occur in the same system cycle, the count drops by exactly one.
- R11: `rst_ni` low at a system edge sets the count to 0 and leaves no pending edge or clear/load state. `zero_o` then equals `cascade_i`.
- R12: With `zero_o` wired to `load_i` and a preset N from 1 to 9, `zero_o` pulses once every N count edges, and the count reloads to N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low system reset |
| cnt_clk_i | input | 1 | Count clock; the rising edge counts while inhibit is low |
| inhibit_i | input | 1 | Inhibit; blocks count-clock edges; its falling edge counts while the count clock is high |
| clear_i | input | 1 | Forces the count to zero (highest priority) |
| load_i | input | 1 | Loads `preset_i` into the count |
| preset_i | input | W | Value to load |
| cascade_i | input | 1 | Enables the zero flag; driven by the neighbouring stage |
| count_o | output | W | Current count |
| zero_o | output | 1 | Decoded, gated zero flag |

## Verification
The hardest case to reach is a cycle in which a rising count clock and a falling inhibit arrive together. This needs the count clock low and the inhibit high in one cycle, then both inputs flipped at once. The vector table sets up that state on purpose. The other hard case is the self-reloading divider, where the load input is driven by the block's own zero flag. The bench switches the load input over to the flag and counts the flag pulses across nine spaced count edges. Each clear/load override is applied on a cycle that also carries a count edge, so a broken priority order shows up as a changed count.

// File: rtl/divn_cnt_pkg.sv
`timescale 1ns/1ps
// Shared types for the divider counter stage.
// Assumes: nothing; holds only the counting-mode selector.
package divn_cnt_pkg;
    typedef enum logic {
        CNT_BCD = 1'b0,  // decade counting, wrap 0 -> 9
        CNT_BIN = 1'b1   // binary counting, wrap 0 -> all ones
    } cnt_mode_e;
endpackage

// File: rtl/divn_edge_det.sv
`timescale 1ns/1ps
// Turns the count-clock and inhibit pins into a one-cycle decrement request.
// Assumes: both pins are synchronous to clk_i. The registered copies reset to
// "clock high, inhibit low" so that a reset never leaves a false edge behind.
module divn_edge_det (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cnt_clk_i,
    input  logic inhibit_i,
    output logic step_o
);
    logic ck_q;
    logic inh_q;
    logic ck_rise;
    logic inh_fall;

    // Purpose: remember last cycle's pin levels.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ck_q  <= 1'b1;
            inh_q <= 1'b0;
        end else begin
            ck_q  <= cnt_clk_i;
            inh_q <= inhibit_i;
        end
    end

    // Purpose: pick out the two active edge kinds and merge them into one request.
    always_comb begin
        ck_rise  = cnt_clk_i & ~ck_q;
        inh_fall = ~inhibit_i & inh_q;
        step_o   = (ck_rise & ~inhibit_i) | (inh_fall & cnt_clk_i);
    end
endmodule

// File: rtl/divn_next_count.sv
`timescale 1ns/1ps
// Next-state logic of the count: clear, then load, then decrement.
// Assumes: step_i holds at most one request per cycle.
module divn_next_count
    import divn_cnt_pkg::*;
#(
    parameter int        W    = 4,
    parameter cnt_mode_e MODE = CNT_BCD
) (
    input  logic [W-1:0] cur_i,
    input  logic         step_i,
    input  logic         clear_i,
    input  logic         load_i,
    input  logic [W-1:0] preset_i,
    output logic [W-1:0] nxt_o
);
    logic [W-1:0] dec;

    // Purpose: build the decrement for the chosen counting mode.
    generate
        if (MODE == CNT_BCD) begin : g_dec_bcd
            localparam logic [W-1:0] WRAP_V = W'(9);
            assign dec = (cur_i == '0) ? WRAP_V : cur_i - W'(1);
        end else begin : g_dec_bin
            assign dec = cur_i - W'(1);
        end
    endgenerate

    // Purpose: apply the priority clear > load > decrement > hold.
    always_comb begin
        if (clear_i)      nxt_o = '0;
        else if (load_i)  nxt_o = preset_i;
        else if (step_i)  nxt_o = dec;
        else              nxt_o = cur_i;
    end
endmodule

// File: rtl/divn_zero_dec.sv
`timescale 1ns/1ps
// Decodes the gated zero flag from the registered clear/load state, the count
// and the live cascade input.
// Assumes: clr_q/ld_q are last cycle's samples, so the flag has no
// combinational path back from load_i (it may be wired to load_i).
module divn_zero_dec #(
    parameter int W = 4
) (
    input  logic         clr_q_i,
    input  logic         ld_q_i,
    input  logic [W-1:0] count_i,
    input  logic         cascade_i,
    output logic         zero_o
);
    // Purpose: choose the flag rule for the current state.
    always_comb begin
        if (clr_q_i)     zero_o = ld_q_i | cascade_i;
        else if (ld_q_i) zero_o = 1'b0;
        else             zero_o = (count_i == '0) & cascade_i;
    end
endmodule

// File: rtl/divn_down_counter.sv
`timescale 1ns/1ps
// One divide-by-N down-counter stage with two count-edge sources and a
// gated zero flag for cascading.
// Assumes: all inputs are synchronous to clk_i; clear and load take effect at
// the next clk_i edge.
module divn_down_counter
    import divn_cnt_pkg::*;
#(
    parameter int        W    = 4,
    parameter cnt_mode_e MODE = CNT_BCD
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         cnt_clk_i,
    input  logic         inhibit_i,
    input  logic         clear_i,
    input  logic         load_i,
    input  logic [W-1:0] preset_i,
    input  logic         cascade_i,
    output logic [W-1:0] count_o,
    output logic         zero_o
);
    logic         step;
    logic [W-1:0] count_q;
    logic [W-1:0] count_d;
    logic         clr_q;
    logic         ld_q;

    divn_edge_det u_edge (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cnt_clk_i (cnt_clk_i),
        .inhibit_i (inhibit_i),
        .step_o    (step)
    );

    divn_next_count #(.W(W), .MODE(MODE)) u_next (
        .cur_i    (count_q),
        .step_i   (step),
        .clear_i  (clear_i),
        .load_i   (load_i),
        .preset_i (preset_i),
        .nxt_o    (count_d)
    );

    // Purpose: hold the count and the sampled clear/load state.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            count_q <= '0;
            clr_q   <= 1'b0;
            ld_q    <= 1'b0;
        end else begin
            count_q <= count_d;
            clr_q   <= clear_i;
            ld_q    <= load_i & ~clear_i;
        end
    end

    divn_zero_dec #(.W(W)) u_zero (
        .clr_q_i   (clr_q),
        .ld_q_i    (ld_q | (clr_q & load_q_raw)),
        .count_i   (count_q),
        .cascade_i (cascade_i),
        .zero_o    (zero_o)
    );

    logic load_q_raw;
    // Purpose: keep the raw load sample for the flag rule while clear is set.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) load_q_raw <= 1'b0;
        else         load_q_raw <= load_i;
    end

    assign count_o = count_q;
endmodule

// File: rtl/divn_down_counter_chk.sv
`timescale 1ns/1ps
// Property checker bound to every divn_down_counter instance.
// Assumes: inputs are synchronous to clk_i; keeps its own copy of the pin levels.
module divn_down_counter_chk
    import divn_cnt_pkg::*;
#(
    parameter int        W    = 4,
    parameter cnt_mode_e MODE = CNT_BCD
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         cnt_clk_i,
    input logic         inhibit_i,
    input logic         clear_i,
    input logic         load_i,
    input logic [W-1:0] preset_i,
    input logic         cascade_i,
    input logic [W-1:0] count_o,
    input logic         zero_o
);
    localparam logic [W-1:0] WRAP_V = (MODE == CNT_BCD) ? W'(9) : {W{1'b1}};

    logic ck_prev;
    logic inh_prev;
    logic edge_seen;

    // Purpose: reference copy of the pin levels from the previous cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ck_prev  <= 1'b1;
            inh_prev <= 1'b0;
        end else begin
            ck_prev  <= cnt_clk_i;
            inh_prev <= inhibit_i;
        end
    end

    assign edge_seen = (cnt_clk_i && !ck_prev && !inhibit_i) ||
                       (!inhibit_i && inh_prev && cnt_clk_i);

    p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (count_o == '0));

    p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && load_i) |=> (count_o == $past(preset_i)));

    p_load_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && load_i) |=> !zero_o);

    p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (zero_o == ($past(load_i) || cascade_i)));

    p_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && !load_i) |=> (zero_o == ((count_o == '0) && cascade_i)));

    p_no_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && !load_i && !edge_seen) |=> $stable(count_o));

    p_one_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && !load_i && edge_seen) |=>
            ((count_o == $past(count_o) - W'(1) && $past(count_o) != '0) ||
             ($past(count_o) == '0 && count_o == WRAP_V)));
endmodule

bind divn_down_counter divn_down_counter_chk #(.W(W), .MODE(MODE)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_clk_i (cnt_clk_i),
    .inhibit_i (inhibit_i),
    .clear_i   (clear_i),
    .load_i    (load_i),
    .preset_i  (preset_i),
    .cascade_i (cascade_i),
    .count_o   (count_o),
    .zero_o    (zero_o)
);

// File: tb/divn_down_counter_tb_top.sv
`timescale 1ns/1ps
module divn_down_counter_tb_top;
    import divn_cnt_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_clk = 1'b0;
    logic       inhibit = 1'b0;
    logic       clear = 1'b0;
    logic       load_r = 1'b0;
    logic [3:0] preset = 4'd0;
    logic       casc = 1'b1;
    logic       fb_en = 1'b0;
    logic       load_mux;
    logic [3:0] count_bcd, count_bin;
    logic       zero_bcd, zero_bin;
    int         n_checks = 0;
    int         n_errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    assign load_mux = fb_en ? zero_bcd : load_r;

    divn_down_counter #(.W(4), .MODE(CNT_BCD)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cnt_clk_i(cnt_clk), .inhibit_i(inhibit),
        .clear_i(clear), .load_i(load_mux), .preset_i(preset), .cascade_i(casc),
        .count_o(count_bcd), .zero_o(zero_bcd)
    );

    divn_down_counter #(.W(4), .MODE(CNT_BIN)) dut_bin_i (
        .clk_i(clk), .rst_ni(rst_n), .cnt_clk_i(cnt_clk), .inhibit_i(inhibit),
        .clear_i(clear), .load_i(load_r), .preset_i(preset), .cascade_i(casc),
        .count_o(count_bin), .zero_o(zero_bin)
    );

    // Fields: clear, load, preset[3:0], cnt_clk, inhibit, cascade, exp_count[3:0], exp_zero
    localparam int NV = 28;
    localparam logic [13:0] VEC [NV] = '{
        {1'b0,1'b1,4'd5, 1'b0,1'b0,1'b1, 4'd5, 1'b0},  // 0  R5 R8 load
        {1'b0,1'b0,4'd5, 1'b0,1'b0,1'b1, 4'd5, 1'b0},  // 1  hold
        {1'b0,1'b0,4'd0, 1'b1,1'b0,1'b1, 4'd4, 1'b0},  // 2  R1 rise
        {1'b0,1'b0,4'd0, 1'b1,1'b0,1'b1, 4'd4, 1'b0},  // 3  R3 held high
        {1'b0,1'b0,4'd0, 1'b0,1'b0,1'b1, 4'd4, 1'b0},  // 4  R3 falling clock
        {1'b0,1'b0,4'd0, 1'b0,1'b1,1'b1, 4'd4, 1'b0},  // 5  R3 inhibit up, clock low
        {1'b0,1'b0,4'd0, 1'b1,1'b1,1'b1, 4'd4, 1'b0},  // 6  R3 rise while inhibited
        {1'b0,1'b0,4'd0, 1'b1,1'b0,1'b1, 4'd3, 1'b0},  // 7  R2 inhibit fall
        {1'b0,1'b0,4'd0, 1'b1,1'b1,1'b1, 4'd3, 1'b0},  // 8  R3 inhibit rise
        {1'b0,1'b0,4'd0, 1'b1,1'b0,1'b1, 4'd2, 1'b0},  // 9  R2
        {1'b0,1'b0,4'd0, 1'b0,1'b0,1'b1, 4'd2, 1'b0},  // 10
        {1'b0,1'b0,4'd0, 1'b1,1'b0,1'b1, 4'd1, 1'b0},  // 11 R1
        {1'b0,1'b0,4'd0, 1'b0,1'b0,1'b1, 4'd1, 1'b0},  // 12
        {1'b0,1'b0,4'd0, 1'b1,1'b0,1'b1, 4'd0, 1'b1},  // 13 R6 zero
        {1'b0,1'b0,4'd0, 1'b1,1'b0,1'b0, 4'd0, 1'b0},  // 14 R6 cascade low
        {1'b0,1'b0,4'd0, 1'b0,1'b0,1'b0, 4'd0, 1'b0},  // 15
        {1'b0,1'b0,4'd0, 1'b1,1'b0,1'b1, 4'd9, 1'b0},  // 16 R9 decade wrap
        {1'b1,1'b0,4'd0, 1'b0,1'b0,1'b0, 4'd0, 1'b0},  // 17 R4 R7 clear
        {1'b1,1'b1,4'd7, 1'b0,1'b0,1'b0, 4'd0, 1'b1},  // 18 R4 R7 clear beats load
        {1'b1,1'b0,4'd0, 1'b0,1'b0,1'b1, 4'd0, 1'b1},  // 19 R7 cascade
        {1'b1,1'b0,4'd0, 1'b1,1'b0,1'b1, 4'd0, 1'b1},  // 20 R4 clear beats edge
        {1'b0,1'b0,4'd0, 1'b0,1'b0,1'b1, 4'd0, 1'b1},  // 21 R6
        {1'b0,1'b1,4'd12,1'b0,1'b0,1'b1, 4'd12,1'b0},  // 22 R5
        {1'b0,1'b1,4'd12,1'b1,1'b0,1'b1, 4'd12,1'b0},  // 23 R5 load beats edge
        {1'b0,1'b0,4'd0, 1'b0,1'b0,1'b1, 4'd12,1'b0},  // 24
        {1'b0,1'b0,4'd0, 1'b1,1'b0,1'b1, 4'd11,1'b0},  // 25 R9 above nine
        {1'b0,1'b0,4'd0, 1'b0,1'b1,1'b1, 4'd11,1'b0},  // 26 set up both edges
        {1'b0,1'b0,4'd0, 1'b1,1'b0,1'b1, 4'd10,1'b0}   // 27 R10 coincident edges
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int zero_pulses;
        // R11 reset state
        repeat (3) tick();
        check("R11 reset count", count_bcd, 0);
        check("R11 reset zero", zero_bcd, 1);
        rst_n = 1'b1;
        tick();

        for (int i = 0; i < NV; i++) begin
            {clear, load_r, preset, cnt_clk, inhibit, casc} = VEC[i][13:5];
            tick();
            check($sformatf("vector %0d count", i), count_bcd, VEC[i][4:1]);
            check($sformatf("vector %0d zero", i), zero_bcd, VEC[i][0]);
        end

        // R11 mid-run reset
        rst_n = 1'b0;
        tick();
        check("R11 mid-run reset count", count_bcd, 0);
        rst_n = 1'b1;
        cnt_clk = 1'b0; inhibit = 1'b0; clear = 1'b0; load_r = 1'b0; casc = 1'b1;
        tick();

        // R9 binary wrap and binary above-nine decrement
        load_r = 1'b1; preset = 4'd0;
        tick();
        load_r = 1'b0;
        tick();
        cnt_clk = 1'b1;
        tick();
        check("R9 binary wrap", count_bin, 15);
        check("R9 decade wrap", count_bcd, 9);
        cnt_clk = 1'b0;
        tick();
        cnt_clk = 1'b1;
        tick();
        check("R9 binary 15 to 14", count_bin, 14);
        cnt_clk = 1'b0;

        // R12 self-reloading divide-by-3
        load_r = 1'b1; preset = 4'd3;
        tick();
        load_r = 1'b0;
        fb_en = 1'b1;
        tick();
        zero_pulses = 0;
        for (int p = 0; p < 9; p++) begin
            cnt_clk = 1'b1;
            tick();
            if (zero_bcd) zero_pulses++;
            cnt_clk = 1'b0;
            tick();
            if (zero_bcd) zero_pulses++;
            tick();
            if (zero_bcd) zero_pulses++;
        end
        check("R12 zero pulses in 9 edges", zero_pulses, 3);
        check("R12 reloaded count", count_bcd, 3);
        fb_en = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule